// File: doc/BRIEF.md
# Two-Group Secure Interrupt Acknowledge Interface

This block is the per-processor side of an interrupt controller. A distributor presents one candidate: the highest-priority pending interrupt, with its ID, its group (0 or 1) and its 8-bit priority. A lower number means a more urgent priority. The block decides whether the candidate is signalled to the processor on the normal interrupt line (`irq_o`) or the fast interrupt line (`fiq_o`). It serves acknowledge reads and end-of-interrupt writes from a small register bus. Every bus access carries a secure/non-secure flag.

Group 0 is the secure, more urgent group. It can reach either line. Group 1 always uses the normal line. Whether an access is allowed depends on the group and on the security flag:
- Group 0 can only be taken or retired by secure software.
- Secure software takes Group 1 work only when it opts in through a control bit.

Accepted interrupts are held on a small stack of active entries. The running priority is the priority of the newest active entry, or idle when the stack is empty. Only a candidate more urgent than the running priority is signalled or acknowledged. This gives preemption and nesting. Completion of the newest entry restores the priority of the entry below it.

Top module: `sec_grp_ack_if`

## Requirements
- R1: After reset:
  - `irq_o` and `fiq_o` are low.
  - The control word and the priority mask read as 0.
  - An acknowledge read returns the spurious ID 1023.
- R2: Register address 0 is the control word, banked by security state.
  - The secure view uses bit 0 for the Group 0 enable, bit 1 for the Group 1 enable, bit 2 for acknowledge-control and bit 3 for fast-interrupt enable. A secure write sets all four bits.
  - The non-secure view shows the Group 1 enable in bit 0, with the other bits reading 0.
  - A non-secure write changes only the Group 1 enable, taken from bit 0.
- R3: Register address 1 is the 8-bit priority mask.
  - Secure reads and writes see the stored value unchanged.
  - A non-secure read returns the stored value shifted left by one when stored bit 7 is set, and 0 otherwise.
  - A non-secure write stores (value>>1)|0x80 only when stored bit 7 is already set; otherwise it is ignored.
- R4: A candidate is signalled when all of these hold:
  - it is valid;
  - its priority is strictly below both the mask and the running priority;
  - the enable for its group is set.

  A signalled Group 1 candidate drives `irq_o`. A signalled Group 0 candidate drives `fiq_o` when fast-interrupt enable is set, and `irq_o` otherwise. The two lines are never high together.
- R5: A non-secure acknowledge read (address 2) while the candidate is Group 0 returns 1023. It pulses nothing and leaves the interrupt state unchanged.
- R6: A secure acknowledge read of a Group 1 candidate succeeds only when acknowledge-control is set; otherwise it returns 1023. A non-secure read may acknowledge Group 1.
- R7: An accepted acknowledge does three things, each visible in the cycle after the request:
  - it returns the candidate ID in the read data;
  - it pulses `ack_o` with `ack_id_o` equal to that ID;
  - it makes the candidate's priority the running priority.
- R8: An acknowledge read returns 1023 and has no effect in either of these cases:
  - the candidate is invalid;
  - its priority is not strictly below both the mask and the running priority.
- R9: An end-of-interrupt write (address 3, data = ID) naming the newest active entry retires it, provided the entry is Group 1 or the write is secure. Retiring pops the entry, restores the previous running priority and pulses `eoi_o` with `eoi_id_o` in the next cycle. A non-secure write naming a Group 0 entry is ignored.
- R10: An end-of-interrupt write whose ID differs from the newest active entry, or that arrives with no active entry, is ignored.
- R11: Up to DEPTH acknowledged interrupts nest. While DEPTH entries are active, an acknowledge read returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_valid_i | input | 1 | Distributor has a pending candidate |
| cand_id_i | input | ID_W | Candidate interrupt ID |
| cand_grp_i | input | 1 | Candidate group: 0 = Group 0, 1 = Group 1 |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| bus_req_i | input | 1 | Register access request, one cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 control, 1 mask, 2 acknowledge, 3 end-of-interrupt |
| bus_wdata_i | input | ID_W | Write data |
| bus_sec_i | input | 1 | 1 = secure access |
| bus_rvalid_o | output | 1 | Read data valid, the cycle after a read request |
| bus_rdata_o | output | ID_W | Read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| ack_o | output | 1 | Pulse: candidate acknowledged |
| ack_id_o | output | ID_W | ID acknowledged |
| eoi_o | output | 1 | Pulse: active interrupt retired |
| eoi_id_o | output | ID_W | ID retired |

## Verification
The following results appear one cycle after the request edge:
- read data;
- the `ack_o`/`eoi_o` pulses and their IDs;
- every register or stack update.

`irq_o` and `fiq_o` follow the candidate and the stored state combinationally.

The bench drives each request on a falling edge and lets one rising edge register it. It samples the registered results on the next falling edge, where the one-cycle pulses are still present. For the line outputs, it waits a short delay after changing the candidate or after the updating edge, and then samples. Running-priority changes are observed indirectly, through whether the unchanged candidate still raises a line.

// File: rtl/sgai_pkg.sv
package sgai_pkg;
  localparam int PRIO_W = 8;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [PRIO_W:0]   rprio_t;   // extra bit encodes "idle"

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_ACK   = 2'd2,
    REG_EOI   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic fiq_en;
    logic ack_ctl;
    logic en_g1;
    logic en_g0;
  } ctrl_t;

  localparam rprio_t RPRIO_IDLE = rprio_t'(1) << PRIO_W;

  // Non-secure view of the mask: halved range, shown shifted up.
  function automatic prio_t ns_mask_view(prio_t pm);
    return pm[PRIO_W-1] ? {pm[PRIO_W-2:0], 1'b0} : '0;
  endfunction

  // Non-secure store: only when the secure side left the top half open.
  function automatic prio_t ns_mask_store(prio_t cur, prio_t wv);
    return cur[PRIO_W-1] ? {1'b1, wv[PRIO_W-1:1]} : cur;
  endfunction

  function automatic logic ack_permitted(logic grp1, logic sec, logic ack_ctl);
    if (!grp1) return sec;
    return sec ? ack_ctl : 1'b1;
  endfunction

  function automatic logic eoi_permitted(logic grp1, logic sec);
    return grp1 | sec;
  endfunction

  function automatic logic outranks(prio_t p, rprio_t lim);
    return {1'b0, p} < lim;
  endfunction
endpackage

// File: rtl/sgai_ctrl_regs.sv
module sgai_ctrl_regs
  import sgai_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_ctrl_i,
  input  logic  wr_mask_i,
  input  logic  sec_i,
  input  prio_t wdata_i,
  output ctrl_t ctrl_o,
  output prio_t mask_o,
  output logic [3:0] ctrl_view_o,
  output prio_t mask_view_o
);
  ctrl_t ctrl_q;
  prio_t mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl_i) begin
      if (sec_i) ctrl_q <= ctrl_t'(wdata_i[3:0]);
      else       ctrl_q.en_g1 <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (wr_mask_i) begin
      mask_q <= sec_i ? wdata_i : ns_mask_store(mask_q, wdata_i);
    end
  end

  assign ctrl_o      = ctrl_q;
  assign mask_o      = mask_q;
  assign ctrl_view_o = sec_i ? 4'(ctrl_q) : {3'b000, ctrl_q.en_g1};
  assign mask_view_o = sec_i ? mask_q : ns_mask_view(mask_q);
endmodule

// File: rtl/sgai_active_stack.sv
module sgai_active_stack
  import sgai_pkg::*;
#(
  parameter int ID_W  = 10,
  parameter int DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [ID_W-1:0] push_id_i,
  input  prio_t           push_prio_i,
  input  logic            push_grp_i,
  output rprio_t          running_o,
  output logic [ID_W-1:0] top_id_o,
  output logic            top_grp_o,
  output logic            empty_o,
  output logic            full_o
);
  localparam int SP_W = $clog2(DEPTH + 1);
  localparam int IX_W = $clog2(DEPTH);

  logic [SP_W-1:0] sp_q;
  logic [ID_W-1:0] id_arr   [DEPTH];
  prio_t           prio_arr [DEPTH];
  logic            grp_arr  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ID_W-1:0] sid_q;
    prio_t           sprio_q;
    logic            sgrp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sid_q   <= '0;
        sprio_q <= '0;
        sgrp_q  <= 1'b0;
      end else if (push_i && sp_q == SP_W'(g)) begin
        sid_q   <= push_id_i;
        sprio_q <= push_prio_i;
        sgrp_q  <= push_grp_i;
      end
    end
    assign id_arr[g]   = sid_q;
    assign prio_arr[g] = sprio_q;
    assign grp_arr[g]  = sgrp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sp_q <= '0;
    else if (push_i && !full_o)   sp_q <= sp_q + SP_W'(1);
    else if (pop_i && !empty_o)   sp_q <= sp_q - SP_W'(1);
  end

  logic [IX_W-1:0] top_ix;
  assign top_ix  = IX_W'(sp_q - SP_W'(1));
  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SP_W'(DEPTH));

  always_comb begin
    running_o = RPRIO_IDLE;
    top_id_o  = '0;
    top_grp_o = 1'b0;
    if (!empty_o) begin
      running_o = {1'b0, prio_arr[top_ix]};
      top_id_o  = id_arr[top_ix];
      top_grp_o = grp_arr[top_ix];
    end
  end
endmodule

// File: rtl/sgai_decide.sv
module sgai_decide
  import sgai_pkg::*;
#(
  parameter int ID_W = 10
) (
  input  logic            cand_valid_i,
  input  logic            cand_grp_i,
  input  prio_t           cand_prio_i,
  input  ctrl_t           ctrl_i,
  input  prio_t           mask_i,
  input  rprio_t          running_i,
  input  logic            full_i,
  input  logic            empty_i,
  input  logic [ID_W-1:0] top_id_i,
  input  logic            top_grp_i,
  input  logic            sec_i,
  input  logic [ID_W-1:0] eoi_id_i,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            ack_go_o,
  output logic            eoi_go_o
);
  logic cand_beats, sig_g0, sig_g1, eoi_match;

  assign cand_beats = cand_valid_i
                    && outranks(cand_prio_i, {1'b0, mask_i})
                    && outranks(cand_prio_i, running_i);
  assign sig_g0 = cand_beats && !cand_grp_i && ctrl_i.en_g0;
  assign sig_g1 = cand_beats &&  cand_grp_i && ctrl_i.en_g1;
  assign fiq_o  = sig_g0 && ctrl_i.fiq_en;
  assign irq_o  = sig_g1 || (sig_g0 && !ctrl_i.fiq_en);

  assign ack_go_o  = cand_beats && !full_i
                   && ack_permitted(cand_grp_i, sec_i, ctrl_i.ack_ctl);
  assign eoi_match = !empty_i && (eoi_id_i == top_id_i);
  assign eoi_go_o  = eoi_match && eoi_permitted(top_grp_i, sec_i);
endmodule

// File: rtl/sec_grp_ack_if.sv
module sec_grp_ack_if
  import sgai_pkg::*;
#(
  parameter int ID_W  = 10,
  parameter int DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cand_valid_i,
  input  logic [ID_W-1:0] cand_id_i,
  input  logic            cand_grp_i,
  input  logic [7:0]      cand_prio_i,
  input  logic            bus_req_i,
  input  logic            bus_wr_i,
  input  logic [1:0]      bus_addr_i,
  input  logic [ID_W-1:0] bus_wdata_i,
  input  logic            bus_sec_i,
  output logic            bus_rvalid_o,
  output logic [ID_W-1:0] bus_rdata_o,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            ack_o,
  output logic [ID_W-1:0] ack_id_o,
  output logic            eoi_o,
  output logic [ID_W-1:0] eoi_id_o
);
  localparam logic [ID_W-1:0] SPURIOUS = '1;

  // Named internal events, also observed by the bound checker.
  ctrl_t           ctl_q;
  prio_t           mask_q;
  logic [3:0]      ctrl_view;
  prio_t           mask_view;
  rprio_t          running_prio;
  logic [ID_W-1:0] top_id;
  logic            top_grp, stk_empty, stk_full;
  logic            ack_go, eoi_go, ack_fire, eoi_fire;
  logic            rd_req, wr_req;
  logic [ID_W-1:0] rd_mux;

  assign rd_req   = bus_req_i && !bus_wr_i;
  assign wr_req   = bus_req_i &&  bus_wr_i;
  assign ack_fire = rd_req && (bus_addr_i == REG_ACK) && ack_go;
  assign eoi_fire = wr_req && (bus_addr_i == REG_EOI) && eoi_go;

  sgai_ctrl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ctrl_i   (wr_req && bus_addr_i == REG_CTRL),
    .wr_mask_i   (wr_req && bus_addr_i == REG_PMASK),
    .sec_i       (bus_sec_i),
    .wdata_i     (bus_wdata_i[PRIO_W-1:0]),
    .ctrl_o      (ctl_q),
    .mask_o      (mask_q),
    .ctrl_view_o (ctrl_view),
    .mask_view_o (mask_view)
  );

  sgai_active_stack #(.ID_W(ID_W), .DEPTH(DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ack_fire),
    .pop_i       (eoi_fire),
    .push_id_i   (cand_id_i),
    .push_prio_i (cand_prio_i),
    .push_grp_i  (cand_grp_i),
    .running_o   (running_prio),
    .top_id_o    (top_id),
    .top_grp_o   (top_grp),
    .empty_o     (stk_empty),
    .full_o      (stk_full)
  );

  sgai_decide #(.ID_W(ID_W)) u_decide (
    .cand_valid_i (cand_valid_i),
    .cand_grp_i   (cand_grp_i),
    .cand_prio_i  (cand_prio_i),
    .ctrl_i       (ctl_q),
    .mask_i       (mask_q),
    .running_i    (running_prio),
    .full_i       (stk_full),
    .empty_i      (stk_empty),
    .top_id_i     (top_id),
    .top_grp_i    (top_grp),
    .sec_i        (bus_sec_i),
    .eoi_id_i     (bus_wdata_i),
    .irq_o        (irq_o),
    .fiq_o        (fiq_o),
    .ack_go_o     (ack_go),
    .eoi_go_o     (eoi_go)
  );

  always_comb begin
    unique case (reg_sel_e'(bus_addr_i))
      REG_CTRL:  rd_mux = ID_W'(ctrl_view);
      REG_PMASK: rd_mux = ID_W'(mask_view);
      REG_ACK:   rd_mux = ack_go ? cand_id_i : SPURIOUS;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
      ack_o        <= 1'b0;
      ack_id_o     <= '0;
      eoi_o        <= 1'b0;
      eoi_id_o     <= '0;
    end else begin
      bus_rvalid_o <= rd_req;
      ack_o        <= ack_fire;
      eoi_o        <= eoi_fire;
      if (rd_req)   bus_rdata_o <= rd_mux;
      if (ack_fire) ack_id_o    <= cand_id_i;
      if (eoi_fire) eoi_id_o    <= top_id;
    end
  end
endmodule

// File: rtl/sec_grp_ack_if_chk.sv
module sec_grp_ack_if_chk
  import sgai_pkg::*;
#(
  parameter int ID_W = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cand_valid_i,
  input logic            cand_grp_i,
  input logic [7:0]      cand_prio_i,
  input logic            bus_req_i,
  input logic            bus_wr_i,
  input logic [1:0]      bus_addr_i,
  input logic            bus_sec_i,
  input logic [ID_W-1:0] bus_rdata_o,
  input logic            irq_o,
  input logic            fiq_o,
  input logic            ack_o,
  input logic            eoi_o,
  input ctrl_t           ctl_q,
  input rprio_t          running_prio,
  input logic            top_grp,
  input logic            stk_empty,
  input logic            ack_go,
  input logic            ack_fire,
  input logic            eoi_fire
);
  logic ack_rd, eoi_wr;
  assign ack_rd = bus_req_i && !bus_wr_i && bus_addr_i == REG_ACK;
  assign eoi_wr = bus_req_i &&  bus_wr_i && bus_addr_i == REG_EOI;

  p_lines_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && fiq_o));

  p_fiq_grp0_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> (cand_valid_i && !cand_grp_i && ctl_q.fiq_en));

  p_ns_grp0_refused_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !bus_sec_i && !cand_grp_i) |=> !ack_o);

  p_sec_grp1_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && bus_sec_i && cand_grp_i && !ctl_q.ack_ctl) |=> !ack_o);

  p_ack_raises_rp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire |=> running_prio == {1'b0, $past(cand_prio_i)});

  p_refused_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !ack_go) |=> (bus_rdata_o == '1 && !ack_o));

  p_ns_grp0_eoi_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && !bus_sec_i && !stk_empty && !top_grp) |=> !eoi_o);

  p_empty_eoi_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && stk_empty) |=> !eoi_o);

  p_rp_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_fire && !eoi_fire) |=> $stable(running_prio));
endmodule

bind sec_grp_ack_if sec_grp_ack_if_chk #(.ID_W(ID_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cand_valid_i (cand_valid_i),
  .cand_grp_i   (cand_grp_i),
  .cand_prio_i  (cand_prio_i),
  .bus_req_i    (bus_req_i),
  .bus_wr_i     (bus_wr_i),
  .bus_addr_i   (bus_addr_i),
  .bus_sec_i    (bus_sec_i),
  .bus_rdata_o  (bus_rdata_o),
  .irq_o        (irq_o),
  .fiq_o        (fiq_o),
  .ack_o        (ack_o),
  .eoi_o        (eoi_o),
  .ctl_q        (ctl_q),
  .running_prio (running_prio),
  .top_grp      (top_grp),
  .stk_empty    (stk_empty),
  .ack_go       (ack_go),
  .ack_fire     (ack_fire),
  .eoi_fire     (eoi_fire)
);

// File: tb/sec_grp_ack_if_tb_top.sv
`timescale 1ns/1ps
module sec_grp_ack_if_tb_top;
  localparam int ID_W = 10;
  localparam logic [31:0] SPUR = 32'd1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic            cand_valid = 1'b0, cand_grp = 1'b0;
  logic [ID_W-1:0] cand_id = '0;
  logic [7:0]      cand_prio = '0;
  logic            req = 1'b0, wr = 1'b0, sec = 1'b0;
  logic [1:0]      addr = '0;
  logic [ID_W-1:0] wdata = '0;
  logic            rvalid, irq, fiq, ack, eoi;
  logic [ID_W-1:0] rdata, ack_id, eoi_id;

  sec_grp_ack_if #(.ID_W(ID_W), .DEPTH(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cand_valid_i(cand_valid), .cand_id_i(cand_id), .cand_grp_i(cand_grp),
    .cand_prio_i(cand_prio),
    .bus_req_i(req), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_sec_i(sec),
    .bus_rvalid_o(rvalid), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq), .ack_o(ack), .ack_id_o(ack_id),
    .eoi_o(eoi), .eoi_id_o(eoi_id)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Request on a falling edge, registered at the rising edge,
  // results sampled at the following falling edge.
  logic [ID_W-1:0] s_rdata, s_ack_id, s_eoi_id;
  logic            s_ack, s_eoi, s_rvalid;
  task automatic bus_op(input logic w, input logic [1:0] a,
                        input logic [ID_W-1:0] d, input logic s);
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d; sec = s;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    s_rdata = rdata; s_rvalid = rvalid;
    s_ack = ack; s_ack_id = ack_id; s_eoi = eoi; s_eoi_id = eoi_id;
    #1;
  endtask

  task automatic set_cand(input logic v, input logic g,
                          input logic [ID_W-1:0] id, input logic [7:0] p);
    @(negedge clk);
    cand_valid = v; cand_grp = g; cand_id = id; cand_prio = p;
    #1;
  endtask

  task automatic ack_expect(input string tag, input logic s, input logic [31:0] exp_id);
    bus_op(1'b0, 2'd2, '0, s);
    chk({tag, " rdata"}, s_rdata, exp_id);
    chk({tag, " ack pulse"}, s_ack, exp_id != SPUR);
    if (exp_id != SPUR) chk({tag, " ack_id"}, s_ack_id, exp_id);
  endtask

  task automatic eoi_expect(input string tag, input logic s,
                            input logic [ID_W-1:0] id, input logic exp_pulse);
    bus_op(1'b1, 2'd3, id, s);
    chk({tag, " eoi pulse"}, s_eoi, exp_pulse);
    if (exp_pulse) chk({tag, " eoi_id"}, s_eoi_id, id);
  endtask

  // {ctrl[3:0], mask[7:0], valid, grp, prio[7:0], exp_irq, exp_fiq}
  localparam logic [23:0] VEC [8] = '{
    {4'b0011, 8'hF0, 1'b1, 1'b0, 8'h10, 1'b1, 1'b0},
    {4'b1011, 8'hF0, 1'b1, 1'b0, 8'h10, 1'b0, 1'b1},
    {4'b1011, 8'hF0, 1'b1, 1'b1, 8'h10, 1'b1, 1'b0},
    {4'b1001, 8'hF0, 1'b1, 1'b1, 8'h10, 1'b0, 1'b0},
    {4'b1010, 8'hF0, 1'b1, 1'b0, 8'h10, 1'b0, 1'b0},
    {4'b0011, 8'h10, 1'b1, 1'b0, 8'h10, 1'b0, 1'b0},
    {4'b0011, 8'h11, 1'b1, 1'b0, 8'h10, 1'b1, 1'b0},
    {4'b0011, 8'hF0, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 irq", irq, 0);
    chk("R1 fiq", fiq, 0);
    bus_op(1'b0, 2'd0, '0, 1'b1); chk("R1 ctrl", s_rdata, 0);
    chk("R1 rvalid", s_rvalid, 1);
    bus_op(1'b0, 2'd1, '0, 1'b1); chk("R1 mask", s_rdata, 0);
    set_cand(1'b1, 1'b0, 10'd3, 8'h10);
    ack_expect("R1 ack at reset", 1'b1, SPUR);

    // R4 vector table
    for (int i = 0; i < 8; i++) begin
      logic [23:0] v;
      v = VEC[i];
      bus_op(1'b1, 2'd0, ID_W'(v[23:20]), 1'b1);
      bus_op(1'b1, 2'd1, ID_W'(v[19:12]), 1'b1);
      set_cand(v[11], v[10], 10'd9, v[9:2]);
      chk($sformatf("R4 vec%0d irq", i), irq, v[1]);
      chk($sformatf("R4 vec%0d fiq", i), fiq, v[0]);
    end

    // R2 banked control word
    bus_op(1'b1, 2'd0, 10'hF, 1'b1);
    bus_op(1'b0, 2'd0, '0, 1'b1); chk("R2 sec view", s_rdata, 10'hF);
    bus_op(1'b0, 2'd0, '0, 1'b0); chk("R2 ns view", s_rdata, 10'h1);
    bus_op(1'b1, 2'd0, 10'h0, 1'b0);
    bus_op(1'b0, 2'd0, '0, 1'b1); chk("R2 ns write g1 only", s_rdata, 10'hD);
    bus_op(1'b0, 2'd0, '0, 1'b0); chk("R2 ns view cleared", s_rdata, 10'h0);

    // R3 restricted mask view
    bus_op(1'b1, 2'd1, 10'h40, 1'b1);
    bus_op(1'b0, 2'd1, '0, 1'b0); chk("R3 ns view low", s_rdata, 0);
    bus_op(1'b1, 2'd1, 10'hFF, 1'b0);
    bus_op(1'b0, 2'd1, '0, 1'b1); chk("R3 ns write ignored", s_rdata, 10'h40);
    bus_op(1'b1, 2'd1, 10'h90, 1'b1);
    bus_op(1'b0, 2'd1, '0, 1'b0); chk("R3 ns view shifted", s_rdata, 10'h20);
    bus_op(1'b1, 2'd1, 10'h50, 1'b0);
    bus_op(1'b0, 2'd1, '0, 1'b1); chk("R3 ns store", s_rdata, 10'hA8);

    // setup: mask open, both groups enabled, ack-control off, FIQ off
    bus_op(1'b1, 2'd1, 10'hFF, 1'b1);
    bus_op(1'b1, 2'd0, 10'h3, 1'b1);

    // R5 non-secure cannot take Group 0
    set_cand(1'b1, 1'b0, 10'h20, 8'h20);
    ack_expect("R5 ns grp0", 1'b0, SPUR);
    chk("R5 state unchanged irq", irq, 1);

    // R6 secure Group 1 gated by ack-control
    set_cand(1'b1, 1'b1, 10'h25, 8'h20);
    ack_expect("R6 sec grp1 no ackctl", 1'b1, SPUR);
    bus_op(1'b1, 2'd0, 10'h7, 1'b1);
    ack_expect("R6 R7 sec grp1 ackctl", 1'b1, 32'h25);
    chk("R7 running raised irq", irq, 0);

    // R9 non-secure completes Group 1
    eoi_expect("R9 ns grp1", 1'b0, 10'h25, 1'b1);
    chk("R9 running restored irq", irq, 1);

    set_cand(1'b1, 1'b1, 10'h31, 8'h30);
    ack_expect("R6 ns grp1", 1'b0, 32'h31);
    eoi_expect("R9 sec grp1", 1'b1, 10'h31, 1'b1);

    // R8 / R11 nesting and preemption
    set_cand(1'b1, 1'b0, 10'd5, 8'h40);
    ack_expect("R7 sec grp0", 1'b1, 32'd5);
    set_cand(1'b1, 1'b0, 10'd6, 8'h50);
    ack_expect("R8 not above running", 1'b1, SPUR);
    set_cand(1'b0, 1'b0, 10'd6, 8'h10);
    ack_expect("R8 invalid candidate", 1'b1, SPUR);
    set_cand(1'b1, 1'b0, 10'd7, 8'h30);
    ack_expect("R11 nested", 1'b1, 32'd7);
    eoi_expect("R9 ns grp0", 1'b0, 10'd7, 1'b0);
    chk("R9 ignored keeps running irq", irq, 0);
    eoi_expect("R10 not newest", 1'b1, 10'd5, 1'b0);
    eoi_expect("R9 sec grp0", 1'b1, 10'd7, 1'b1);
    chk("R9 restored to outer irq", irq, 1);
    eoi_expect("R9 outer", 1'b1, 10'd5, 1'b1);
    eoi_expect("R10 empty", 1'b1, 10'd5, 1'b0);

    // R11 full stack
    set_cand(1'b1, 1'b0, 10'd10, 8'h80); ack_expect("R11 d1", 1'b1, 32'd10);
    set_cand(1'b1, 1'b0, 10'd11, 8'h70); ack_expect("R11 d2", 1'b1, 32'd11);
    set_cand(1'b1, 1'b0, 10'd12, 8'h60); ack_expect("R11 d3", 1'b1, 32'd12);
    set_cand(1'b1, 1'b0, 10'd13, 8'h50); ack_expect("R11 d4", 1'b1, 32'd13);
    set_cand(1'b1, 1'b0, 10'd14, 8'h40); ack_expect("R11 full", 1'b1, SPUR);
    eoi_expect("R11 pop4", 1'b1, 10'd13, 1'b1);
    eoi_expect("R11 pop3", 1'b1, 10'd12, 1'b1);
    eoi_expect("R11 pop2", 1'b1, 10'd11, 1'b1);
    eoi_expect("R11 pop1", 1'b1, 10'd10, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule